// File: doc/BRIEF.md
# Memory Multiply-Accumulate Sequencer

This block computes a dot product of two arrays held in memory. After a start strobe it takes two pointers, an element count, an element size and a 96-bit accumulator seed split into three 32-bit words. For each pair of elements it reads one element through each pointer over a read port that allows one outstanding request. It sign-extends both elements, multiplies them as signed values, adds the 64-bit sign-extended product into the 96-bit sum with a carry chain across the three words, advances both pointers and decrements the count. The loop runs until the count is zero.

When the loop ends, the top accumulator word is cut to its low 16 bits and sign-extended again. The sign flag and the overflow flag come from that trimmed word, and a one-cycle done pulse marks the point where every result is valid. The final pointers, the zero count and the three accumulator words stay on the outputs until the next start.

The controller has seven states. ST_IDLE waits for start. ST_TEST tests the count. ST_FETCH_A reads the first operand. ST_FETCH_B reads the second operand. ST_ACCUM adds the product and steps the count. ST_TRIM cuts the top word and sets the flags. ST_REPORT raises done. The transitions are: start taken (IDLE to TEST), count zero (TEST to TRIM), count nonzero (TEST to FETCH_A), first response (FETCH_A to FETCH_B), second response (FETCH_B to ACCUM), loop back (ACCUM to TEST), trim done (TRIM to REPORT) and release (REPORT to IDLE).

Top module: `dotprod_walker`

## Requirements
- R1: After reset, busy, done and mem_req are low, and the flags, count, pointers and accumulator words are zero.
- R2: A start with a count of zero issues no memory request. The low and middle accumulator words keep their seed values, and the block still trims the top word, sets the flags and pulses done.
- R3: Each iteration reads from the first pointer and then from the second pointer. mem_req stays high with mem_addr held steady until mem_rvalid arrives, and each pointer is read only after the previous response.
- R4: The size code (0 byte, 1 halfword, 2 word, 3 also word) appears on mem_size. Each pointer moves by 1, 2 or 4 bytes per element, modulo 2^32.
- R5: The element sits in the low bits of mem_rdata. Bytes extend from bit 7 and halfwords from bit 15, and any read-data bits above the element have no effect on the result.
- R6: The signed 64-bit product, sign-extended to 96 bits, is added to {hi, mid, lo} with carries rippling from the low word to the high word.
- R7: The count drops by exactly one per element pair and is zero when done is asserted.
- R8: At completion, acc_hi becomes bits 15:0 of the high word, sign-extended to 32 bits.
- R9: flag_sign equals bit 31 of the final acc_hi. flag_ovf is set exactly when the final acc_hi is neither all zeros nor all ones.
- R10: done is high for exactly one cycle and only after every result output holds its final value.
- R11: A start pulse while busy is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; sampled only while idle |
| elem_size | input | 2 | Element size code: 0 byte, 1 halfword, 2 or 3 word |
| ptr_a_init | input | 32 | Start address of the first array |
| ptr_b_init | input | 32 | Start address of the second array |
| count_init | input | 32 | Number of element pairs |
| acc_lo_init | input | 32 | Accumulator seed, low word |
| acc_mid_init | input | 32 | Accumulator seed, middle word |
| acc_hi_init | input | 32 | Accumulator seed, high word |
| mem_req | output | 1 | Read request, held until answered |
| mem_addr | output | 32 | Read byte address |
| mem_size | output | 2 | Element size code of the read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read data, element right-aligned |
| busy | output | 1 | High from the accepted start to the end of done |
| done | output | 1 | One-cycle completion pulse |
| ptr_a | output | 32 | First pointer |
| ptr_b | output | 32 | Second pointer |
| count | output | 32 | Remaining element pairs |
| acc_lo | output | 32 | Accumulator low word |
| acc_mid | output | 32 | Accumulator middle word |
| acc_hi | output | 32 | Accumulator high word |
| flag_sign | output | 1 | Sign of the trimmed high word |
| flag_ovf | output | 1 | Trimmed high word is not a pure sign fill |

## Verification
The assertions assume that memory raises mem_rvalid only while mem_req is high, and that each response is consumed on the edge where it is presented, so mem_addr must stay stable only across cycles with no response. The bench memory model follows this. On every falling edge it answers a live request after a latency of zero to two cycles, and it drops mem_rvalid on the next falling edge. The model fills the read-data bits above the element with a fixed junk pattern, so any sign-extension error shows up in the accumulator. Start pulses sent during a run carry different operands, so an accepted one would change the results.

// File: rtl/dpw_pkg.sv
package dpw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TEST,
        ST_FETCH_A,
        ST_FETCH_B,
        ST_ACCUM,
        ST_TRIM,
        ST_REPORT
    } seq_state_e;

    localparam logic [1:0] ESZ_BYTE = 2'd0;
    localparam logic [1:0] ESZ_HALF = 2'd1;
    localparam logic [1:0] ESZ_WORD = 2'd2;

endpackage

// File: rtl/dpw_ctrl.sv
module dpw_ctrl
    import dpw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic count_zero,
    input  logic rvalid,
    output logic busy,
    output logic done,
    output logic req,
    output logic sel_b,
    output logic take,
    output logic cap_a,
    output logic cap_b,
    output logic acc_en,
    output logic trim
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_TEST;
            ST_TEST:    state_d = count_zero ? ST_TRIM : ST_FETCH_A;
            ST_FETCH_A: if (rvalid) state_d = ST_FETCH_B;
            ST_FETCH_B: if (rvalid) state_d = ST_ACCUM;
            ST_ACCUM:   state_d = ST_TEST;
            ST_TRIM:    state_d = ST_REPORT;
            ST_REPORT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy   = 1'b1;
        done   = 1'b0;
        req    = 1'b0;
        sel_b  = 1'b0;
        take   = 1'b0;
        cap_a  = 1'b0;
        cap_b  = 1'b0;
        acc_en = 1'b0;
        trim   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                take = start;
            end
            ST_TEST: ;
            ST_FETCH_A: begin
                req   = 1'b1;
                cap_a = rvalid;
            end
            ST_FETCH_B: begin
                req   = 1'b1;
                sel_b = 1'b1;
                cap_b = rvalid;
            end
            ST_ACCUM:  acc_en = 1'b1;
            ST_TRIM:   trim   = 1'b1;
            ST_REPORT: done   = 1'b1;
            default:   busy   = 1'b0;
        endcase
    end

endmodule

// File: rtl/dpw_extend.sv
module dpw_extend
    import dpw_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [1:0]        esz,
    input  logic [WORD_W-1:0] raw,
    output logic [WORD_W-1:0] ext
);

    always_comb begin
        unique case (esz)
            ESZ_BYTE: ext = {{(WORD_W-8){raw[7]}}, raw[7:0]};
            ESZ_HALF: ext = {{(WORD_W-16){raw[15]}}, raw[15:0]};
            default:  ext = raw;
        endcase
    end

endmodule

// File: rtl/dpw_acc.sv
module dpw_acc #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 3,
    parameter int KEEP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [NWORDS*WORD_W-1:0] init_flat,
    input  logic                     add_en,
    input  logic [2*WORD_W-1:0]      prod,
    input  logic                     trim,
    output logic [NWORDS*WORD_W-1:0] words_flat,
    output logic                     sign_flag,
    output logic                     ovf_flag
);

    localparam int FILL_W = WORD_W - KEEP_W;
    localparam int TOP    = NWORDS - 1;

    logic [WORD_W-1:0] acc_q  [NWORDS];
    logic [WORD_W-1:0] addend [NWORDS];
    logic [WORD_W-1:0] sum    [NWORDS];
    logic [NWORDS-1:0] cy;
    logic [WORD_W-1:0] hi_trim;

    assign cy[0] = 1'b0;

    generate
        for (genvar i = 0; i < NWORDS; i++) begin : g_word
            if (i < 2) begin : g_prod
                assign addend[i] = prod[i*WORD_W +: WORD_W];
            end else begin : g_fill
                assign addend[i] = {WORD_W{prod[2*WORD_W-1]}};
            end
            if (i < TOP) begin : g_mid
                assign {cy[i+1], sum[i]} = {1'b0, acc_q[i]} + {1'b0, addend[i]}
                                         + {{WORD_W{1'b0}}, cy[i]};
            end else begin : g_top
                assign sum[i] = acc_q[i] + addend[i] + {{(WORD_W-1){1'b0}}, cy[i]};
            end
            assign words_flat[i*WORD_W +: WORD_W] = acc_q[i];
        end
    endgenerate

    assign hi_trim = {{FILL_W{acc_q[TOP][KEEP_W-1]}}, acc_q[TOP][KEEP_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NWORDS; k++) acc_q[k] <= '0;
        end else if (load) begin
            for (int k = 0; k < NWORDS; k++) acc_q[k] <= init_flat[k*WORD_W +: WORD_W];
        end else if (add_en) begin
            for (int k = 0; k < NWORDS; k++) acc_q[k] <= sum[k];
        end else if (trim) begin
            acc_q[TOP] <= hi_trim;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sign_flag <= 1'b0;
            ovf_flag  <= 1'b0;
        end else if (trim) begin
            sign_flag <= hi_trim[WORD_W-1];
            ovf_flag  <= (hi_trim != '0) && (hi_trim != '1);
        end
    end

endmodule

// File: rtl/dotprod_walker.sv
module dotprod_walker
    import dpw_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int KEEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        elem_size,
    input  logic [ADDR_W-1:0] ptr_a_init,
    input  logic [ADDR_W-1:0] ptr_b_init,
    input  logic [CNT_W-1:0]  count_init,
    input  logic [WORD_W-1:0] acc_lo_init,
    input  logic [WORD_W-1:0] acc_mid_init,
    input  logic [WORD_W-1:0] acc_hi_init,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] ptr_a,
    output logic [ADDR_W-1:0] ptr_b,
    output logic [CNT_W-1:0]  count,
    output logic [WORD_W-1:0] acc_lo,
    output logic [WORD_W-1:0] acc_mid,
    output logic [WORD_W-1:0] acc_hi,
    output logic              flag_sign,
    output logic              flag_ovf
);

    localparam int NWORDS = 3;
    localparam int PROD_W = 2 * WORD_W;

    logic                     sel_b, take, cap_a, cap_b, acc_en, trim;
    logic [1:0]               esz_q;
    logic [ADDR_W-1:0]        pa_q, pb_q, step;
    logic [CNT_W-1:0]         cnt_q;
    logic [WORD_W-1:0]        opa_q, opb_q, elem_ext;
    logic signed [PROD_W-1:0] prod;
    logic [NWORDS*WORD_W-1:0] words;

    dpw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .count_zero (cnt_q == '0),
        .rvalid     (mem_rvalid),
        .busy       (busy),
        .done       (done),
        .req        (mem_req),
        .sel_b      (sel_b),
        .take       (take),
        .cap_a      (cap_a),
        .cap_b      (cap_b),
        .acc_en     (acc_en),
        .trim       (trim)
    );

    dpw_extend #(.WORD_W(WORD_W)) u_ext (
        .esz (esz_q),
        .raw (mem_rdata),
        .ext (elem_ext)
    );

    always_comb begin
        unique case (esz_q)
            ESZ_BYTE: step = ADDR_W'(1);
            ESZ_HALF: step = ADDR_W'(2);
            default:  step = ADDR_W'(4);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            esz_q <= ESZ_WORD;
            pa_q  <= '0;
            pb_q  <= '0;
            cnt_q <= '0;
            opa_q <= '0;
            opb_q <= '0;
        end else begin
            if (take) begin
                esz_q <= elem_size;
                pa_q  <= ptr_a_init;
                pb_q  <= ptr_b_init;
                cnt_q <= count_init;
            end
            if (cap_a) begin
                opa_q <= elem_ext;
                pa_q  <= pa_q + step;
            end
            if (cap_b) begin
                opb_q <= elem_ext;
                pb_q  <= pb_q + step;
            end
            if (acc_en) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign prod = $signed(opa_q) * $signed(opb_q);

    dpw_acc #(.WORD_W(WORD_W), .NWORDS(NWORDS), .KEEP_W(KEEP_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (take),
        .init_flat  ({acc_hi_init, acc_mid_init, acc_lo_init}),
        .add_en     (acc_en),
        .prod       (prod),
        .trim       (trim),
        .words_flat (words),
        .sign_flag  (flag_sign),
        .ovf_flag   (flag_ovf)
    );

    assign mem_addr = sel_b ? pb_q : pa_q;
    assign mem_size = esz_q;
    assign ptr_a    = pa_q;
    assign ptr_b    = pb_q;
    assign count    = cnt_q;
    assign acc_lo   = words[0*WORD_W +: WORD_W];
    assign acc_mid  = words[1*WORD_W +: WORD_W];
    assign acc_hi   = words[2*WORD_W +: WORD_W];

endmodule

// File: rtl/dpw_check.sv
module dpw_check #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  count,
    input logic [WORD_W-1:0] acc_hi,
    input logic              flag_sign,
    input logic              flag_ovf
);

    p_idle_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            (count == $past(count) || count == $past(count) - CNT_W'(1)));

    p_done_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count == '0));

    p_hi_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc_hi[WORD_W-1:15] == '0 || acc_hi[WORD_W-1:15] == '1));

    p_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_sign == acc_hi[WORD_W-1]));

    p_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_ovf == (acc_hi != '0 && acc_hi != '1)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !mem_req));

endmodule

bind dotprod_walker dpw_check #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_dpw_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .mem_addr   (mem_addr),
    .busy       (busy),
    .done       (done),
    .count      (count),
    .acc_hi     (acc_hi),
    .flag_sign  (flag_sign),
    .flag_ovf   (flag_ovf)
);

// File: tb/test_dotprod_walker.sv
`timescale 1ns/1ps
module test_dotprod_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  elem_size = 2'd0;
    logic [31:0] ptr_a_init = '0, ptr_b_init = '0, count_init = '0;
    logic [31:0] acc_lo_init = '0, acc_mid_init = '0, acc_hi_init = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, flag_sign, flag_ovf;
    logic [31:0] ptr_a, ptr_b, count, acc_lo, acc_mid, acc_hi;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dotprod_walker i_dotprod_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .elem_size(elem_size),
        .ptr_a_init(ptr_a_init), .ptr_b_init(ptr_b_init), .count_init(count_init),
        .acc_lo_init(acc_lo_init), .acc_mid_init(acc_mid_init), .acc_hi_init(acc_hi_init),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .ptr_a(ptr_a), .ptr_b(ptr_b), .count(count),
        .acc_lo(acc_lo), .acc_mid(acc_mid), .acc_hi(acc_hi),
        .flag_sign(flag_sign), .flag_ovf(flag_ovf)
    );

    logic [7:0]  mem_b [256];
    logic [31:0] log_addr [32];
    logic [1:0]  log_size [32];
    int          n_reads = 0;
    int          wait_cnt = 0;

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] raw_at(input logic [31:0] addr, input logic [1:0] sz);
        logic [31:0] r = 32'hC3C3_C3C3;
        for (int k = 0; k < nbytes(sz); k++) r[8*k +: 8] = mem_b[8'(addr + 32'(k))];
        return r;
    endfunction

    function automatic logic [31:0] elem_at(input logic [31:0] addr, input logic [1:0] sz);
        logic [31:0] r = raw_at(addr, sz);
        if (sz == 2'd0) return {{24{r[7]}}, r[7:0]};
        if (sz == 2'd1) return {{16{r[15]}}, r[15:0]};
        return r;
    endfunction

    // memory model: answers a live request after 0..2 cycles, on falling edges
    always @(negedge clk) begin
        logic gave;
        gave = mem_rvalid;
        mem_rvalid = 1'b0;
        if (gave) wait_cnt = 0;
        if (mem_req) begin
            if (wait_cnt >= (n_reads % 3)) begin
                mem_rvalid = 1'b1;
                mem_rdata  = raw_at(mem_addr, mem_size);
                if (n_reads < 32) begin
                    log_addr[n_reads] = mem_addr;
                    log_size[n_reads] = mem_size;
                end
                n_reads++;
            end else begin
                wait_cnt++;
            end
        end else begin
            wait_cnt = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] sz, input logic [31:0] pa, input logic [31:0] pb,
                       input logic [31:0] cnt, input logic [31:0] lo, input logic [31:0] mid,
                       input logic [31:0] hi, input bit glitch);
        logic [95:0] e_acc;
        logic [31:0] e_hi, step;
        int          cyc;
        step  = 32'(nbytes(sz));
        e_acc = {hi, mid, lo};
        for (int i = 0; i < int'(cnt); i++) begin
            logic [31:0] ea, eb;
            longint p;
            ea = elem_at(pa + 32'(i) * step, sz);
            eb = elem_at(pb + 32'(i) * step, sz);
            p = longint'($signed(ea)) * longint'($signed(eb));
            e_acc = e_acc + {{32{p[63]}}, 64'(p)};
        end
        e_hi = {{16{e_acc[79]}}, e_acc[79:64]};

        @(negedge clk);
        n_reads = 0;
        elem_size = sz; ptr_a_init = pa; ptr_b_init = pb; count_init = cnt;
        acc_lo_init = lo; acc_mid_init = mid; acc_hi_init = hi;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 4000) begin
            if (glitch && cyc == 3) begin
                start = 1'b1; ptr_a_init = 32'h55; ptr_b_init = 32'h99; count_init = 32'd7;
                acc_lo_init = 32'h1234_5678; elem_size = 2'd1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk("R10 done seen", {31'd0, done}, 32'd1);
        chk("R4 ptr_a", ptr_a, pa + cnt * step);
        chk("R4 ptr_b", ptr_b, pb + cnt * step);
        chk("R7 count", count, 32'd0);
        chk("R5 R6 acc_lo", acc_lo, e_acc[31:0]);
        chk("R6 acc_mid", acc_mid, e_acc[63:32]);
        chk("R8 acc_hi", acc_hi, e_hi);
        chk("R9 sign", {31'd0, flag_sign}, {31'd0, e_hi[31]});
        chk("R9 ovf", {31'd0, flag_ovf}, {31'd0, (e_hi != 32'd0 && e_hi != 32'hFFFF_FFFF)});
        chk(cnt == 0 ? "R2 no reads" : "R3 read count", 32'(n_reads), 2 * cnt);
        for (int i = 0; i < n_reads && i < 32; i++) begin
            chk("R3 read addr", log_addr[i],
                ((i % 2) == 0 ? pa : pb) + 32'(i / 2) * step);
            chk("R4 read size", {30'd0, log_size[i]}, {30'd0, sz});
        end
        if (glitch) chk("R11 start ignored", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk("R10 done one cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act hung exp finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem_b[i] = 8'(i * 73 + 29);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 req", {31'd0, mem_req}, 32'd0);
        chk("R1 flags", {30'd0, flag_sign, flag_ovf}, 32'd0);
        chk("R1 acc", acc_lo | acc_mid | acc_hi | count | ptr_a | ptr_b, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int sz = 0; sz < 4; sz++) begin
            for (int c = 0; c < 4; c++) begin
                int cnt;
                cnt = (c == 0) ? 0 : (c == 1) ? 1 : (c == 2) ? 3 : 6;
                run(2'(sz), 32'h10 + 32'(sz * 3), 32'hFFFF_FFF0 + 32'(c), 32'(cnt),
                    32'd0, 32'd0, 32'd0, 1'b0);
                run(2'(sz), 32'h40 + 32'(c * 5), 32'h81, 32'(cnt),
                    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_7FFF, 1'b0);
                run(2'(sz), 32'hC7, 32'h23 + 32'(sz), 32'(cnt),
                    32'h8000_0000, 32'h0, 32'hFFFF_0000, 1'b0);
            end
        end
        // R2 R8 R9 zero-count trimming corners
        run(2'd2, 32'h0, 32'h4, 32'd0, 32'h1, 32'h2, 32'h0001_2345, 1'b0);
        run(2'd2, 32'h0, 32'h4, 32'd0, 32'h1, 32'h2, 32'hABCD_FFFF, 1'b0);
        run(2'd2, 32'h0, 32'h4, 32'd0, 32'h1, 32'h2, 32'h0000_8000, 1'b0);
        run(2'd0, 32'h0, 32'h4, 32'd0, 32'h1, 32'h2, 32'h7FFF_0000, 1'b0);
        // R11 start pulse mid-run
        run(2'd2, 32'h20, 32'h60, 32'd4, 32'h5, 32'h6, 32'h7, 1'b1);
        run(2'd0, 32'h33, 32'hA0, 32'd8, 32'h0, 32'h0, 32'h0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule